// File: doc/BRIEF.md
# Presence-Tagged Synchronization Memory

This block is a small word-addressed store in which every word carries a single presence tag, either full or empty. Producers and consumers meet on a word through atomic operations. Each operation tests the tag and updates the tag and the data together in one clock cycle. A consumer can read a word and empty it in the same step, or it can read the word and leave it full. A producer can write a word and fill it. If the tag is in the wrong state for the operation, the request does not complete. The block instead reports a synchronization fault, which names the operation, the address and the requester's context number, so that a trap handler can park that context.

Each successful fill emits a release pulse that carries the filled address. A scheduler uses this pulse to wake every context that waits on that word. A bulk clear walks the whole store, one word per cycle, and sets every tag to empty and every data word to zero. While the walk runs, the block reports busy and discards incoming requests. Requests arrive on a single port, one per cycle, and all results appear as registered one-cycle pulses in the cycle after the request.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every tag is empty and busy_o is low; each word has its own tag, so filling one address leaves every other address empty.
- R2: A take request (req_op_i = 2'b00) on a full word returns its data on rd_data_o with rd_valid_o high one cycle later, and leaves the word empty.
- R3: A take request on an empty word produces no read; instead fault_o pulses one cycle later with fault_op_o, fault_addr_o and fault_ctx_o equal to the request's opcode, address and context, and data and tag are left unchanged.
- R4: A put request (req_op_i = 2'b01) on an empty word stores req_wdata_i and sets the tag to full; release_o pulses with release_addr_o equal to the address in the same cycle the tag becomes full.
- R5: A put request on a full word raises a fault (as in R3, fault_op_o = 2'b01) and leaves the stored data and the tag unchanged.
- R6: A peek request (req_op_i = 2'b10) on a full word returns the data with rd_valid_o high one cycle later and leaves the tag full.
- R7: A peek request on an empty word raises a fault (fault_op_o = 2'b10) and returns no data.
- R8: A clear request (req_op_i = 2'b11) raises busy_o from the next cycle for exactly DEPTH cycles, during which the words are cleared one per cycle; when busy_o falls, every tag is empty.
- R9: Requests presented while busy_o is high are ignored: they give no read, fault or release, and they change no tag.
- R10: Outputs are single-cycle pulses, and a request sees the effect of the request accepted in the cycle before it, so a put followed at once by a take on the same address returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 00 take, 01 put, 10 peek, 11 clear |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Data for put |
| req_ctx_i | input | CW | Requesting context number |
| busy_o | output | 1 | Bulk clear in progress |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | DW | Data returned by take or peek |
| fault_o | output | 1 | Synchronization fault pulse |
| fault_op_o | output | 2 | Opcode of the faulting request |
| fault_addr_o | output | AW | Address of the faulting request |
| fault_ctx_o | output | CW | Context of the faulting request |
| release_o | output | 1 | Word became full pulse |
| release_addr_o | output | AW | Address that became full |

## Verification
The assertions assume that the requester only treats a request as accepted while busy_o is low, and that after the asynchronous reset the store is treated as holding empty tags with undefined data until a clear or a put defines a word. The stimulus drives each request on the falling clock edge for a single cycle and samples the results on the next falling edge. It reads data only from words that it has put earlier. It also issues one put while a clear is running, to confirm that the put is dropped rather than assumed never to occur.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [1:0] {
    OP_TAKE  = 2'b00,
    OP_PUT   = 2'b01,
    OP_PEEK  = 2'b10,
    OP_CLEAR = 2'b11
  } fe_op_e;
endpackage

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [AW-1:0]    set_idx_i,
  input  logic             clr_en_i,
  input  logic [AW-1:0]    clr_idx_i,
  output logic [DEPTH-1:0] tags_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    tags_o[g] <= 1'b0;
      else if (set_en_i && set_idx_i == AW'(g))       tags_o[g] <= 1'b1;
      else if (clr_en_i && clr_idx_i == AW'(g))       tags_o[g] <= 1'b0;
    end
  end

  // R4
  set_clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_en_i && clr_en_i && set_idx_i == clr_idx_i));
endmodule

// File: rtl/fe_data_array.sv
module fe_data_array #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/fe_clear_seq.sv
module fe_clear_seq #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [AW-1:0] idx_o
);
  localparam logic [AW-1:0] LastIdx = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (busy_o) begin
      if (idx_o == LastIdx) busy_o <= 1'b0;
      else                  idx_o  <= idx_o + 1'b1;
    end else if (start_i) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end
  end

  // R8
  sweep_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> idx_o == $past(idx_o) + 1'b1);
  // R8
  sweep_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> idx_o == '0);
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int CW    = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [CW-1:0] req_ctx_i,
  output logic          busy_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          fault_o,
  output logic [1:0]    fault_op_o,
  output logic [AW-1:0] fault_addr_o,
  output logic [CW-1:0] fault_ctx_o,
  output logic          release_o,
  output logic [AW-1:0] release_addr_o
);
  import fe_pkg::*;

  logic [DEPTH-1:0] tags;
  logic [DW-1:0]    rdata;
  logic [AW-1:0]    sweep_idx;
  logic             busy;
  logic             acc, full_hit;
  logic             take_ok, put_ok, peek_ok, clr_start, bad;
  fe_op_e           op;

  assign op       = fe_op_e'(req_op_i);
  assign acc      = req_valid_i && !busy;
  assign full_hit = tags[req_addr_i];

  assign take_ok   = acc && op == OP_TAKE && full_hit;
  assign put_ok    = acc && op == OP_PUT  && !full_hit;
  assign peek_ok   = acc && op == OP_PEEK && full_hit;
  assign clr_start = acc && op == OP_CLEAR;
  assign bad       = acc && ((op == OP_TAKE && !full_hit) ||
                             (op == OP_PUT  &&  full_hit) ||
                             (op == OP_PEEK && !full_hit));

  fe_clear_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (clr_start),
    .busy_o  (busy),
    .idx_o   (sweep_idx)
  );

  fe_tag_array #(.DEPTH(DEPTH)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (put_ok),
    .set_idx_i (req_addr_i),
    .clr_en_i  (take_ok || busy),
    .clr_idx_i (busy ? sweep_idx : req_addr_i),
    .tags_o    (tags)
  );

  fe_data_array #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .clk_i   (clk_i),
    .we_i    (put_ok || busy),
    .widx_i  (busy ? sweep_idx : req_addr_i),
    .wdata_i (busy ? '0 : req_wdata_i),
    .ridx_i  (req_addr_i),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o     <= 1'b0;
      rd_data_o      <= '0;
      fault_o        <= 1'b0;
      fault_op_o     <= '0;
      fault_addr_o   <= '0;
      fault_ctx_o    <= '0;
      release_o      <= 1'b0;
      release_addr_o <= '0;
    end else begin
      rd_valid_o <= take_ok || peek_ok;
      fault_o    <= bad;
      release_o  <= put_ok;
      if (take_ok || peek_ok) rd_data_o <= rdata;
      if (bad) begin
        fault_op_o   <= req_op_i;
        fault_addr_o <= req_addr_i;
        fault_ctx_o  <= req_ctx_i;
      end
      if (put_ok) release_addr_o <= req_addr_i;
    end
  end

  assign busy_o = busy;

  // R4
  rel_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> tags[release_addr_o]);
  // R2
  take_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op == OP_TAKE && full_hit |=> !tags[$past(req_addr_i)] && rd_valid_o);
  // R6
  peek_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op == OP_PEEK && full_hit |=> tags[$past(req_addr_i)]);
  // R3
  fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !rd_valid_o && !release_o);
  // R3
  fault_keeps_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> tags[fault_addr_o] == $past(tags[fault_addr_o]));
  // R8
  clear_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> tags == '0);
  // R9
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && req_valid_i |=> !rd_valid_o && !fault_o && !release_o);
endmodule

// File: tb/fe_sync_mem_test.sv
module fe_sync_mem_test;
  localparam int ClkPeriod = 10;
  localparam int DEPTH = 16;
  localparam int DW = 16;
  localparam int CW = 2;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] req_ctx = '0;
  logic          busy, rd_valid, fault, release_p;
  logic [DW-1:0] rd_data;
  logic [1:0]    fault_op;
  logic [AW-1:0] fault_addr, release_addr;
  logic [CW-1:0] fault_ctx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  fe_sync_mem #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ctx_i(req_ctx),
    .busy_o(busy), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .fault_o(fault), .fault_op_o(fault_op), .fault_addr_o(fault_addr),
    .fault_ctx_o(fault_ctx), .release_o(release_p), .release_addr_o(release_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one request for one cycle; returns at the negedge after the capturing edge
  task automatic op1(input logic [1:0] op, input int addr, input int data, input int ctx);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(addr);
    req_wdata = DW'(data); req_ctx = CW'(ctx);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_fault(input string req, input logic [1:0] op, input int addr, input int ctx);
    chk(fault == 1'b1, req, fault, 1);
    chk(fault_op == op && fault_addr == AW'(addr) && fault_ctx == CW'(ctx), req,
        {fault_op, fault_addr, fault_ctx}, {op, AW'(addr), CW'(ctx)});
    chk(!rd_valid && !release_p, req, {rd_valid, release_p}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !rd_valid && !fault && !release_p, "R1 reset outputs",
        {busy, rd_valid, fault, release_p}, 0);
    op1(2'b00, 3, 0, 2);
    expect_fault("R1 R3 take empty after reset", 2'b00, 3, 2);
  endtask

  task automatic t_put_take;
    op1(2'b01, 3, 16'hA5A5, 1);
    chk(release_p && release_addr == 4'd3 && !fault, "R4 put release", {release_p, release_addr}, {1'b1, 4'd3});
    op1(2'b01, 3, 16'h1111, 3);
    expect_fault("R5 put full", 2'b01, 3, 3);
    op1(2'b10, 3, 0, 0);
    chk(rd_valid && rd_data == 16'hA5A5, "R6 R5 peek data kept", rd_data, 16'hA5A5);
    op1(2'b10, 3, 0, 0);
    chk(rd_valid && rd_data == 16'hA5A5, "R6 peek leaves full", rd_data, 16'hA5A5);
    op1(2'b00, 3, 0, 1);
    chk(rd_valid && rd_data == 16'hA5A5 && !fault, "R2 take data", rd_data, 16'hA5A5);
    op1(2'b00, 3, 0, 1);
    expect_fault("R2 take emptied", 2'b00, 3, 1);
    @(negedge clk);
    chk(!fault && !rd_valid && !release_p, "R10 pulse one cycle", {fault, rd_valid, release_p}, 0);
  endtask

  task automatic t_peek_empty;
    op1(2'b10, 5, 0, 3);
    expect_fault("R7 peek empty", 2'b10, 5, 3);
  endtask

  task automatic t_independent;
    op1(2'b01, 0, 16'h0BEE, 0);
    op1(2'b00, 1, 0, 2);
    expect_fault("R1 neighbour empty", 2'b00, 1, 2);
    op1(2'b00, 0, 0, 0);
    chk(rd_valid && rd_data == 16'h0BEE, "R1 own tag", rd_data, 16'h0BEE);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b01; req_addr = 4'd7; req_wdata = 16'h7777; req_ctx = 2'd1;
    @(negedge clk);
    chk(release_p && release_addr == 4'd7, "R10 R4 b2b release", release_addr, 7);
    req_op = 2'b00;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rd_valid && rd_data == 16'h7777 && !fault, "R10 b2b take", rd_data, 16'h7777);
  endtask

  task automatic t_clear;
    int n;
    op1(2'b01, 9, 16'h9999, 0);
    op1(2'b01, 15, 16'hFFFF, 0);
    op1(2'b11, 0, 0, 0);
    n = 0;
    chk(busy == 1'b1, "R8 busy rises", busy, 1);
    req_valid = 1'b1; req_op = 2'b01; req_addr = 4'd4; req_wdata = 16'h4444;
    @(negedge clk);
    n++;
    req_valid = 1'b0;
    chk(!release_p && !fault && !rd_valid, "R9 ignored while busy", {release_p, fault, rd_valid}, 0);
    while (busy && n < 4 * DEPTH) begin
      @(negedge clk);
      n++;
    end
    chk(n == DEPTH, "R8 busy length", n, DEPTH);
    op1(2'b00, 9, 0, 1);
    expect_fault("R8 cleared tag 9", 2'b00, 9, 1);
    op1(2'b10, 15, 0, 2);
    expect_fault("R8 cleared tag 15", 2'b10, 15, 2);
    op1(2'b10, 4, 0, 3);
    expect_fault("R9 busy put dropped", 2'b10, 4, 3);
    op1(2'b01, 9, 16'h1234, 0);
    op1(2'b00, 9, 0, 0);
    chk(rd_valid && rd_data == 16'h1234, "R8 usable after clear", rd_data, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_put_take();
    t_peek_empty();
    t_independent();
    t_back_to_back();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule